// File: doc/BRIEF.md
# Stable Hang Signature Detector

This block decides whether a MAC DMA engine or a baseband receiver has locked up in one of a few known stuck states. When `start` is pulsed while the block is idle, it takes a snapshot of five 32-bit status words. It then compares the live words against that snapshot once per clock for 50 further samples. Any difference ends the check at once with "no hang". Only a set of words that stays frozen over the whole run is classified.

Classification looks at the snapshot. The baseband observation word goes through an ordered table of mask/value pairs. The four MAC debug words are split into small state fields, which are compared against two multi-field signatures. A baseband hit wins over any MAC result, and the MAC check can be left out through the request enables. The result is a one-cycle `done` pulse carrying a 3-bit hang code. Code 0 stands for a moving status, an unknown frozen pattern, or a disabled check.

Top module: `hang_sig_detect`

## Requirements
- R1: After reset, `done` and `hang_code` are 0.
- R2: A `start` seen while idle captures all five status words and both enables at that edge. The block then compares the live words with the capture on each of the next 50 clock edges. If every compare is equal, `done` is 1 for the cycle after the 50th of those edges, carrying the classified code.
- R3: If the live words differ from the capture at the k-th compare (1..50), the check ends there. `done` rises after that edge, k cycles after the start edge, with code 0. This holds for bits that no signature looks at.
- R4: A `start` while a check is running is ignored. The running check keeps its timing and produces exactly one `done`.
- R5: Baseband table, first match in this order gives the code: (word & 0x7E000B00) == 0x1E000000 gives 1; (word & 0x7E000B00) == 0x52000B00 gives 2; (word & 0x7E000B00) == 0x18000B00 gives 3; (word & 0x7E7FFFEF) == 0x00702400 gives 3. Bits outside the mask are ignored.
- R6: MAC signature 1 (code 4) needs two things. First, one of ten 5-bit chain-state fields must equal 0x06. Six of these fields are in `dma_chain_a` at bits [5i+4:5i] for i=0..5, and four are in `dma_chain_b` at the same positions for i=0..3. Second, `dma_cmpl[1:0]` must equal 1. Fields not on a 5-bit boundary do not count.
- R7: MAC signature 2 (code 5) needs all three fields of `dma_queue` to match: bits [21:18] == 0x9, bits [25:22] == 0x8 and bits [28:26] == 0x4.
- R8: A signature with any one of its fields wrong does not match. When both MAC signatures match, code 4 is reported.
- R9: When the baseband check is enabled and hits, its code is reported and the MAC result is not used.
- R10: With `bb_req` low the baseband table is not used, and with `mac_req` low the MAC signatures are not used. A frozen pattern that matches no enabled signature gives code 0.
- R11: `done` lasts exactly one cycle. `hang_code` is 0 whenever `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a check (taken only while idle) |
| bb_req | input | 1 | Include the baseband table in the check |
| mac_req | input | 1 | Include the MAC signatures in the check |
| bb_obs | input | 32 | Baseband observation status word |
| dma_chain_a | input | 32 | MAC debug word with six chain-state fields |
| dma_chain_b | input | 32 | MAC debug word with four chain-state fields |
| dma_cmpl | input | 32 | MAC debug word holding the completion state |
| dma_queue | input | 32 | MAC debug word holding the queue stitch/fetch/complete states |
| done | output | 1 | One-cycle pulse: the check has finished |
| hang_code | output | 3 | Hang code, valid with `done` (0 = none) |

## Verification
A frozen check reports 50 cycles after the clock edge that took `start`. A check aborted by a change visible at the k-th compare edge reports k cycles after that edge. The bench tests abort delays of 1, 25 and 50. For every check, the driver queues the expected code together with the expected `done` cycle, counted from a free-running edge counter. At each falling edge the monitor pops the queue on `done` and compares both the code and the cycle. A second `done`, or any `done` with nothing queued, also counts as a mismatch, and this is how the ignored mid-check `start` and the pulse width are covered.

// File: rtl/hsd_pkg.sv
package hsd_pkg;

  localparam int WORD_W     = 32;
  localparam int CODE_W     = 3;
  localparam int BB_ENTRIES = 4;

  localparam int DCU_FW     = 5;
  localparam int DCU_A_N    = 6;
  localparam int DCU_B_N    = 4;

  localparam logic [DCU_FW-1:0] SIG1_CHAIN  = 5'h06;
  localparam logic [1:0]        SIG1_CMPL   = 2'h1;
  localparam logic [3:0]        SIG2_STITCH = 4'h9;
  localparam logic [3:0]        SIG2_FETCH  = 4'h8;
  localparam logic [2:0]        SIG2_QCMPL  = 3'h4;

  localparam int STITCH_LSB = 18;
  localparam int FETCH_LSB  = 22;
  localparam int QCMPL_LSB  = 26;

  typedef enum logic [CODE_W-1:0] {
    HC_NONE  = 3'd0,
    HC_BB_A  = 3'd1,
    HC_BB_B  = 3'd2,
    HC_BB_C  = 3'd3,
    HC_MAC_1 = 3'd4,
    HC_MAC_2 = 3'd5
  } hang_code_e;

  function automatic logic [WORD_W-1:0] bb_mask(input int idx);
    case (idx)
      3:       bb_mask = 32'h7E7F_FFEF;
      default: bb_mask = 32'h7E00_0B00;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] bb_value(input int idx);
    case (idx)
      0:       bb_value = 32'h1E00_0000;
      1:       bb_value = 32'h5200_0B00;
      2:       bb_value = 32'h1800_0B00;
      default: bb_value = 32'h0070_2400;
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] bb_code(input int idx);
    case (idx)
      0:       bb_code = HC_BB_A;
      1:       bb_code = HC_BB_B;
      default: bb_code = HC_BB_C;
    endcase
  endfunction

endpackage

// File: rtl/hsd_stable_mon.sv
module hsd_stable_mon #(
  parameter int W         = 160,
  parameter int N_SAMPLES = 50,
  localparam int CW       = $clog2(N_SAMPLES + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] live,
  output logic [W-1:0] snap,
  output logic         busy,
  output logic         ev_ok,
  output logic         ev_abort
);

  logic [CW-1:0] cnt;
  logic          same;
  logic          last;

  assign same     = (live == snap);
  assign last     = (cnt == CW'(N_SAMPLES - 1));
  assign ev_ok    = busy && same && last;
  assign ev_abort = busy && !same;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      snap <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
        snap <= live;
      end
    end else if (!same || last) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3
  abort_ends_chk: assert property (@(posedge clk) disable iff (rst)
    busy && !same |=> !busy);

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> cnt < CW'(N_SAMPLES));

  // R4
  busy_start_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy && start && same && !last |=> busy && $stable(snap));

endmodule

// File: rtl/hsd_bb_match.sv
module hsd_bb_match
  import hsd_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic              hit,
  output logic [CODE_W-1:0] code
);

  logic [BB_ENTRIES-1:0] entry_hit;

  for (genvar i = 0; i < BB_ENTRIES; i++) begin : g_entry
    assign entry_hit[i] = ((word & bb_mask(i)) == bb_value(i));
  end

  always_comb begin
    code = HC_NONE;
    for (int i = BB_ENTRIES - 1; i >= 0; i--) begin
      if (entry_hit[i]) code = bb_code(i);
    end
  end

  assign hit = |entry_hit;

endmodule

// File: rtl/hsd_mac_match.sv
module hsd_mac_match
  import hsd_pkg::*;
(
  input  logic [WORD_W-1:0] chain_a,
  input  logic [WORD_W-1:0] chain_b,
  input  logic [WORD_W-1:0] cmpl_w,
  input  logic [WORD_W-1:0] queue_w,
  output logic              sig1,
  output logic              sig2
);

  localparam int NF = DCU_A_N + DCU_B_N;

  logic [NF-1:0] chain_hit;

  for (genvar i = 0; i < DCU_A_N; i++) begin : g_fa
    assign chain_hit[i] = (chain_a[DCU_FW*i +: DCU_FW] == SIG1_CHAIN);
  end
  for (genvar i = 0; i < DCU_B_N; i++) begin : g_fb
    assign chain_hit[DCU_A_N+i] = (chain_b[DCU_FW*i +: DCU_FW] == SIG1_CHAIN);
  end

  assign sig1 = (|chain_hit) && (cmpl_w[1:0] == SIG1_CMPL);
  assign sig2 = (queue_w[STITCH_LSB +: 4] == SIG2_STITCH) &&
                (queue_w[FETCH_LSB  +: 4] == SIG2_FETCH)  &&
                (queue_w[QCMPL_LSB  +: 3] == SIG2_QCMPL);

  logic unused_bits;
  assign unused_bits = ^{chain_a[WORD_W-1:DCU_FW*DCU_A_N],
                         chain_b[WORD_W-1:DCU_FW*DCU_B_N],
                         cmpl_w[WORD_W-1:2],
                         queue_w[WORD_W-1:QCMPL_LSB+3],
                         queue_w[STITCH_LSB-1:0]};

endmodule

// File: rtl/hang_sig_detect.sv
module hang_sig_detect
  import hsd_pkg::*;
#(
  parameter int N_SAMPLES = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              bb_req,
  input  logic              mac_req,
  input  logic [WORD_W-1:0] bb_obs,
  input  logic [WORD_W-1:0] dma_chain_a,
  input  logic [WORD_W-1:0] dma_chain_b,
  input  logic [WORD_W-1:0] dma_cmpl,
  input  logic [WORD_W-1:0] dma_queue,
  output logic              done,
  output logic [CODE_W-1:0] hang_code
);

  localparam int SNAP_W = 5 * WORD_W;

  logic [SNAP_W-1:0] live, snap;
  logic              busy, ev_ok, ev_abort;
  logic              bb_en_q, mac_en_q;
  logic              bb_hit, sig1, sig2;
  logic [CODE_W-1:0] bb_cd, sel_code;

  assign live = {bb_obs, dma_chain_a, dma_chain_b, dma_cmpl, dma_queue};

  hsd_stable_mon #(.W(SNAP_W), .N_SAMPLES(N_SAMPLES)) u_mon (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .live     (live),
    .snap     (snap),
    .busy     (busy),
    .ev_ok    (ev_ok),
    .ev_abort (ev_abort)
  );

  hsd_bb_match u_bb (
    .word (snap[4*WORD_W +: WORD_W]),
    .hit  (bb_hit),
    .code (bb_cd)
  );

  hsd_mac_match u_mac (
    .chain_a (snap[3*WORD_W +: WORD_W]),
    .chain_b (snap[2*WORD_W +: WORD_W]),
    .cmpl_w  (snap[1*WORD_W +: WORD_W]),
    .queue_w (snap[0 +: WORD_W]),
    .sig1    (sig1),
    .sig2    (sig2)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bb_en_q  <= 1'b0;
      mac_en_q <= 1'b0;
    end else if (!busy && start) begin
      bb_en_q  <= bb_req;
      mac_en_q <= mac_req;
    end
  end

  always_comb begin
    if (bb_en_q && bb_hit)    sel_code = bb_cd;
    else if (mac_en_q && sig1) sel_code = HC_MAC_1;
    else if (mac_en_q && sig2) sel_code = HC_MAC_2;
    else                       sel_code = HC_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      hang_code <= HC_NONE;
    end else begin
      done      <= ev_ok || ev_abort;
      hang_code <= ev_ok ? sel_code : HC_NONE;
    end
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  code_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> hang_code == HC_NONE);

  // R9
  bb_first_chk: assert property (@(posedge clk) disable iff (rst)
    ev_ok && bb_en_q && bb_hit |=> done && hang_code == $past(bb_cd));

  // R8
  sig_order_chk: assert property (@(posedge clk) disable iff (rst)
    ev_ok && mac_en_q && sig1 && !(bb_en_q && bb_hit) |=> hang_code == HC_MAC_1);

endmodule

// File: tb/hang_sig_detect_tb.sv
module hang_sig_detect_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NS         = 50;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, bb_req = 1'b0, mac_req = 1'b0;
  logic [31:0] obs = '0, da = '0, db = '0, dc = '0, dq = '0;
  logic        done;
  logic [2:0]  code;

  always #(CLK_PERIOD/2) clk = ~clk;

  hang_sig_detect u_dut (
    .clk(clk), .rst(rst), .start(start), .bb_req(bb_req), .mac_req(mac_req),
    .bb_obs(obs), .dma_chain_a(da), .dma_chain_b(db), .dma_cmpl(dc),
    .dma_queue(dq), .done(done), .hang_code(code)
  );

  typedef struct {
    logic [2:0] code;
    int         at;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0, n_bad = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && done) begin
      if (q.size() == 0) begin
        check(1'b0, "R11 unexpected done (R4)", int'(code), -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(code == e.code, e.tag, int'(code), int'(e.code));
        check(cyc == e.at, {e.tag, " timing"}, cyc, e.at);
      end
    end
  end

  // driver: k = compare index where a change is seen (0 = none)
  task automatic run(input logic [31:0] o, a, b, c, qq, input bit be, me,
                     input logic [2:0] ec, input string tag, input int k,
                     input logic [31:0] xo, xq, input int pulse_at);
    @(negedge clk);
    obs = o; da = a; db = b; dc = c; dq = qq;
    bb_req = be; mac_req = me; start = 1'b1;
    q.push_back('{(k > 0) ? 3'd0 : ec, cyc + 1 + ((k > 0) ? k : NS), tag});
    @(negedge clk);
    start = 1'b0;
    bb_req = ~be; mac_req = ~me;
    for (int i = 1; i <= NS + 2; i++) begin
      if (i == k) begin obs = obs ^ xo; dq = dq ^ xq; end
      if (i == pulse_at) start = 1'b1;
      else start = 1'b0;
      if (q.size() == 0) break;
      @(negedge clk);
    end
    start = 1'b0;
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    check(code == 3'd0, "R1 code after reset", int'(code), 0);

    // R5 table entries, bits outside masks set
    run(32'h9E00_00FF, 0, 0, 0, 0, 1, 1, 3'd1, "R5 entry0", 0, 0, 0, 0);
    run(32'h5200_0B00, 0, 0, 0, 0, 1, 1, 3'd2, "R5 entry1", 0, 0, 0, 0);
    run(32'h1800_0B00, 0, 0, 0, 0, 1, 1, 3'd3, "R5 entry2", 0, 0, 0, 0);
    run(32'h8070_2410, 0, 0, 0, 0, 1, 1, 3'd3, "R5 entry3", 0, 0, 0, 0);
    // R6 chain field in second word slot 3, and first word slot 5
    run(0, 0, 32'd6 << 15, 32'd1, 0, 1, 1, 3'd4, "R6 sig1 word b", 0, 0, 0, 0);
    run(0, 32'd6 << 25, 0, 32'hFFFF_FFFD, 0, 1, 1, 3'd4, "R6 sig1 word a", 0, 0, 0, 0);
    run(0, 32'd6 << 3, 0, 32'd1, 0, 1, 1, 3'd0, "R6 misaligned field", 0, 0, 0, 0);
    // R7
    run(0, 0, 0, 0, 32'hF224_0001, 1, 1, 3'd5, "R7 sig2", 0, 0, 0, 0);
    // R8 partial and both
    run(0, 0, 32'd6, 32'd2, 0, 1, 1, 3'd0, "R8 sig1 cmpl wrong", 0, 0, 0, 0);
    run(0, 0, 0, 0, 32'h1264_0000, 1, 1, 3'd0, "R8 sig2 fetch wrong", 0, 0, 0, 0);
    run(0, 0, 32'd6, 32'd1, 32'h1224_0000, 1, 1, 3'd4, "R8 both sigs", 0, 0, 0, 0);
    // R9
    run(32'h5200_0B00, 0, 32'd6, 32'd1, 0, 1, 1, 3'd2, "R9 bb over mac", 0, 0, 0, 0);
    // R10
    run(32'h1E00_0000, 0, 0, 0, 0, 0, 1, 3'd0, "R10 bb disabled", 0, 0, 0, 0);
    run(32'h1E00_0000, 0, 32'd6, 32'd1, 0, 0, 1, 3'd4, "R10 bb off mac used", 0, 0, 0, 0);
    run(0, 0, 32'd6, 32'd1, 0, 1, 0, 3'd0, "R10 mac disabled", 0, 0, 0, 0);
    run(32'h1234_5678, 0, 0, 0, 0, 1, 1, 3'd0, "R10 unknown frozen", 0, 0, 0, 0);
    // R3 aborts
    run(32'h1E00_0000, 0, 0, 0, 0, 1, 1, 3'd1, "R3 abort k1", 1, 32'h1, 0, 0);
    run(0, 0, 0, 0, 32'h1224_0000, 1, 1, 3'd5, "R3 abort k25", 25, 0, 32'h1, 0);
    run(32'h1E00_0000, 0, 0, 0, 0, 1, 1, 3'd1, "R3 abort k50", NS, 32'h8000_0000, 0, 0);
    // R4 start during check
    run(32'h5200_0B00, 0, 0, 0, 0, 1, 1, 3'd2, "R4 start ignored", 0, 0, 0, 10);
    // R2 plain frozen check after all of the above
    run(32'h1800_0B00, 0, 0, 0, 0, 1, 1, 3'd3, "R2 frozen timing", 0, 0, 0, 0);
    check(done == 1'b0 && code == 3'd0, "R11 idle outputs", int'(code), 0);

    summary();
    $finish;
  end

endmodule